// File: doc/BRIEF.md
# Index Distance Meter

This block measures how far an incremental encoder travels between successive index marks on one channel. A quadrature decoder upstream supplies a one-cycle step strobe with a direction bit, plus the index track already synchronized to the block clock. An internal interval counter follows the steps as a signed two's complement displacement. It restarts at every rising edge of the index signal, and the value it held just before that edge is then captured.

The first index edge after reset only arms the counter. The interval that ends at the second index edge is latched once into a reference register and never overwritten until the next reset. Every interval after that is written into a rolling update register, and a one-cycle strobe marks each rewrite. If no index mark arrives, the counter stops at its signed limit instead of wrapping, and an overflow flag is raised for the rest of that interval.

Top module: `idx_dist_meter`

## Requirements
- R1: After a synchronous reset, ref_dist, upd_dist, ref_valid, upd_valid, upd_pulse and ovf_flag are all 0.
- R2: Steps seen before the first index edge after reset are ignored. The first index edge stores nothing in either register and starts the count at zero.
- R3: A step with step_up=1 adds one and a step with step_up=0 subtracts one. A captured distance is the number of up steps minus the number of down steps, in CNT_W-bit two's complement.
- R4: The interval that ends at the second index edge after reset is written to ref_dist, and ref_valid goes to 1. Both then keep their values until reset.
- R5: Every later interval is written to upd_dist. upd_valid stays 1 from the first such write onward, and upd_pulse is 1 for exactly the one cycle after each write.
- R6: A capture happens at the clock edge where index_in is first sampled high, and is visible right after that edge. A step sampled on that same edge belongs to the new interval, so the new count starts at +1 or -1.
- R7: Only a rising edge of index_in is an index event. Holding index_in high for several cycles gives one capture, and steps keep counting while it is high.
- R8: The count saturates at 2^(CNT_W-1)-1 going up and at -2^(CNT_W-1) going down. A step that would pass the limit sets ovf_flag, and the next index edge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | One count step in this cycle |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| index_in | input | 1 | Synchronized index track, active high |
| ref_dist | output | CNT_W | First measured interval (two's complement) |
| ref_valid | output | 1 | ref_dist holds a measurement |
| upd_dist | output | CNT_W | Most recent measured interval after the first |
| upd_valid | output | 1 | upd_dist holds a measurement |
| upd_pulse | output | 1 | One-cycle strobe after each upd_dist write |
| ovf_flag | output | 1 | Current interval hit the counter limit |

## Verification
The bench sends steps before the first index edge. A design that counts them or captures on the first edge would report a reference distance or set ref_valid too early. The bench also applies a step in the same cycle as an index edge, which exposes a design that drops that step or adds it to the interval being captured. It holds the index high over several cycles to catch a design that triggers on the level instead of the edge. It drives the count to exactly the limit and then one step past it, in both directions. A design that wraps would report a small or sign-flipped distance, and one with an off-by-one limit would raise the overflow flag one step early.

// File: rtl/idm_pkg.sv
package idm_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } step_dir_e;
endpackage

// File: rtl/idm_index_edge.sv
module idm_index_edge (
  input  logic clk,
  input  logic rst,
  input  logic index_in,
  output logic evt
);
  logic idx_q;

  always_ff @(posedge clk) begin
    if (rst) idx_q <= 1'b0;
    else     idx_q <= index_in;
  end

  assign evt = index_in & ~idx_q;

  // R7
  single_evt_chk: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt);
endmodule

// File: rtl/idm_interval_cnt.sv
module idm_interval_cnt #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             step_en,
  input  logic             step_up,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             armed
);
  import idm_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] NEG_ONE = {CNT_W{1'b1}};

  step_dir_e        dir;
  logic             at_lim;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] start_val;

  always_comb begin
    dir       = step_dir_e'(step_up);
    at_lim    = (dir == DIR_UP) ? (cnt == CNT_MAX) : (cnt == CNT_MIN);
    nxt       = (dir == DIR_UP) ? (cnt + ONE) : (cnt - ONE);
    start_val = step_en ? ((dir == DIR_UP) ? ONE : NEG_ONE) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ovf   <= 1'b0;
      armed <= 1'b0;
    end else if (evt) begin
      armed <= 1'b1;
      ovf   <= 1'b0;
      cnt   <= start_val;
    end else if (armed && step_en) begin
      if (at_lim) ovf <= 1'b1;
      else        cnt <= nxt;
    end
  end

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |-> cnt == '0);
  // R8
  hold_max_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && step_en && step_up && !evt) |=> cnt == CNT_MAX);
  // R8
  hold_min_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MIN && step_en && !step_up && !evt) |=> cnt == CNT_MIN);
  // R8
  ovf_at_limit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> (cnt == CNT_MAX || cnt == CNT_MIN));
endmodule

// File: rtl/idm_capture.sv
module idm_capture #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             armed,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] ref_dist,
  output logic             ref_valid,
  output logic [CNT_W-1:0] upd_dist,
  output logic             upd_valid,
  output logic             upd_pulse
);
  logic take;

  assign take = evt & armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_dist  <= '0;
      ref_valid <= 1'b0;
      upd_dist  <= '0;
      upd_valid <= 1'b0;
      upd_pulse <= 1'b0;
    end else begin
      upd_pulse <= 1'b0;
      if (take) begin
        if (!ref_valid) begin
          ref_dist  <= cnt;
          ref_valid <= 1'b1;
        end else begin
          upd_dist  <= cnt;
          upd_valid <= 1'b1;
          upd_pulse <= 1'b1;
        end
      end
    end
  end

  // R4
  ref_locked_chk: assert property (@(posedge clk) disable iff (rst)
    ref_valid |=> (ref_valid && $stable(ref_dist)));
  // R5
  upd_order_chk: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |-> (upd_valid && ref_valid));
  // R5
  upd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> upd_valid);
  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |=> !upd_pulse);
endmodule

// File: rtl/idx_dist_meter.sv
module idx_dist_meter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             step_up,
  input  logic             index_in,
  output logic [CNT_W-1:0] ref_dist,
  output logic             ref_valid,
  output logic [CNT_W-1:0] upd_dist,
  output logic             upd_valid,
  output logic             upd_pulse,
  output logic             ovf_flag
);
  logic             evt;
  logic             armed;
  logic [CNT_W-1:0] cnt;

  idm_index_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .index_in (index_in),
    .evt      (evt)
  );

  idm_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .step_en (step_en),
    .step_up (step_up),
    .cnt     (cnt),
    .ovf     (ovf_flag),
    .armed   (armed)
  );

  idm_capture #(.CNT_W(CNT_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .armed     (armed),
    .cnt       (cnt),
    .ref_dist  (ref_dist),
    .ref_valid (ref_valid),
    .upd_dist  (upd_dist),
    .upd_valid (upd_valid),
    .upd_pulse (upd_pulse)
  );

  // R6
  capture_needs_index_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_valid) |-> $past(index_in));
endmodule

// File: tb/idx_dist_meter_tb.sv
module idx_dist_meter_tb;
  localparam int W = 8;
  localparam int NROW = 6;
  // columns: up steps, down steps, expected distance
  localparam int TBL [NROW][3] = '{
    '{5, 0, 5}, '{10, 3, 7}, '{2, 6, -4},
    '{0, 0, 0}, '{40, 40, 0}, '{100, 0, 100}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_en = 1'b0;
  logic step_up = 1'b0;
  logic index_in = 1'b0;
  logic [W-1:0] ref_dist, upd_dist;
  logic ref_valid, upd_valid, upd_pulse, ovf_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  idx_dist_meter #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .step_en(step_en), .step_up(step_up),
    .index_in(index_in), .ref_dist(ref_dist), .ref_valid(ref_valid),
    .upd_dist(upd_dist), .upd_valid(upd_valid), .upd_pulse(upd_pulse),
    .ovf_flag(ovf_flag)
  );

  function automatic int sx(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit up);
    @(negedge clk); step_en = 1'b1; step_up = up;
    @(negedge clk); step_en = 1'b0;
  endtask

  task automatic idx_pulse();
    @(negedge clk); index_in = 1'b1;
    @(negedge clk); index_in = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", "ref_valid", int'(ref_valid), 0);
    chk("R1", "upd_valid", int'(upd_valid), 0);
    chk("R1", "ovf_flag", int'(ovf_flag), 0);
    chk("R1", "ref_dist", sx(ref_dist), 0);

    // R2 steps before arming ignored, first index stores nothing
    for (int k = 0; k < 20; k++) step(1'b1);
    idx_pulse();
    chk("R2", "ref_valid after first index", int'(ref_valid), 0);
    chk("R2", "upd_valid after first index", int'(upd_valid), 0);

    // R3/R4/R5 table walk
    for (int i = 0; i < NROW; i++) begin
      for (int k = 0; k < TBL[i][0]; k++) step(1'b1);
      for (int k = 0; k < TBL[i][1]; k++) step(1'b0);
      idx_pulse();
      if (i == 0) begin
        chk("R4", "ref_dist", sx(ref_dist), TBL[i][2]);
        chk("R4", "ref_valid", int'(ref_valid), 1);
        chk("R5", "upd_valid before second interval", int'(upd_valid), 0);
      end else begin
        chk("R3", "upd_dist", sx(upd_dist), TBL[i][2]);
        chk("R5", "upd_pulse", int'(upd_pulse), 1);
        chk("R4", "ref_dist held", sx(ref_dist), TBL[0][2]);
        @(negedge clk);
        chk("R5", "upd_pulse one cycle", int'(upd_pulse), 0);
        chk("R5", "upd_valid sticky", int'(upd_valid), 1);
      end
    end

    // R6 step coincident with index edge starts the new interval
    for (int k = 0; k < 3; k++) step(1'b1);
    @(negedge clk); index_in = 1'b1; step_en = 1'b1; step_up = 1'b1;
    @(negedge clk); index_in = 1'b0; step_en = 1'b0;
    chk("R6", "upd_dist excludes coincident step", sx(upd_dist), 3);
    for (int k = 0; k < 4; k++) step(1'b1);
    idx_pulse();
    chk("R6", "coincident step in new interval", sx(upd_dist), 5);

    // R7 index held high: one capture, steps keep counting
    step(1'b1); step(1'b1);
    @(negedge clk); index_in = 1'b1; step_en = 1'b1; step_up = 1'b1;
    @(negedge clk);
    chk("R7", "capture on rising edge", sx(upd_dist), 2);
    chk("R7", "upd_pulse at edge", int'(upd_pulse), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7", "no capture while held", int'(upd_pulse), 0);
    end
    index_in = 1'b0; step_en = 1'b0;
    step(1'b1); step(1'b1);
    idx_pulse();
    chk("R7", "interval across held index", sx(upd_dist), 6);

    // R8 saturation upward
    for (int k = 0; k < 127; k++) step(1'b1);
    chk("R8", "ovf at exact max", int'(ovf_flag), 0);
    step(1'b1);
    chk("R8", "ovf past max", int'(ovf_flag), 1);
    step(1'b1); step(1'b1);
    idx_pulse();
    chk("R8", "upd_dist saturated max", sx(upd_dist), 127);
    chk("R8", "ovf cleared by index", int'(ovf_flag), 0);

    // R8 saturation downward
    for (int k = 0; k < 128; k++) step(1'b0);
    chk("R8", "ovf at exact min", int'(ovf_flag), 0);
    step(1'b0);
    chk("R8", "ovf past min", int'(ovf_flag), 1);
    idx_pulse();
    chk("R8", "upd_dist saturated min", sx(upd_dist), -128);
    chk("R4", "ref_dist still held", sx(ref_dist), 5);

    // R1/R2 reset mid-run re-arms the sequence
    step(1'b1);
    do_reset();
    chk("R1", "ref_valid after reset", int'(ref_valid), 0);
    chk("R1", "upd_dist after reset", sx(upd_dist), 0);
    idx_pulse();
    chk("R2", "first index after reset", int'(ref_valid), 0);
    step(1'b0); step(1'b0); step(1'b0);
    idx_pulse();
    chk("R4", "new ref after reset", sx(ref_dist), -3);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule